// File: doc/BRIEF.md
# Multi-channel conversion sequencer

This block steps an external analog-to-digital converter through a contiguous window of channel addresses. Software programs a first and a final address, a run-mode bit and a trigger-source bit. A pass can be launched in two ways. The first is an internal strobe. The second is an external trigger pin, which is honoured only when that source is selected. For every channel in the window, the sequencer presents the address and raises a one-cycle start pulse. It then waits for the converter's done strobe. It reports the channel that finished, and flags the done strobe of the final channel of the pass.

Two run modes exist. In single-pass mode the window is walked once and the block returns to idle. In continuous mode, which is available only with the internal trigger source, the window is walked again and again. A window whose final address does not exceed its first address shrinks to the first channel alone. A new internal strobe always abandons the current pass and starts afresh. The converter is assumed to discard any conversion still in flight when it receives a new start pulse.

Top module: `chan_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `conv_start` and `done_valid` are 0.
- R2: With `ext_trig_en`=0 and `auto_mode`=0, an `int_trig` starts a pass. The pass converts every channel from `start_addr` up to `end_addr` once, in ascending order. After the final channel's done, `busy` drops to 0.
- R3: `conv_start` is high for exactly one cycle per channel, and `conv_chan` holds the channel address during that cycle. The first pulse comes in the cycle after the trigger is sampled. Each later pulse comes in the cycle after the previous channel's done.
- R4: `done_valid` is high in each cycle where `conv_done` is sampled while a conversion is awaited. In that cycle `done_chan` gives the channel that finished. `done_last` is high only together with the done of the final channel of the pass.
- R5: When `end_addr` <= `start_addr`, a pass consists of the `start_addr` channel alone.
- R6: In continuous mode (`auto_mode`=1, `ext_trig_en`=0), the cycle after the final done issues `start_addr` again, and the window repeats indefinitely. A one-channel window repeats that channel.
- R7: If `auto_mode` is 0 or `ext_trig_en` is 1 when a pass's final done arrives, continuous running ends and the block goes idle after that pass.
- R8: With `ext_trig_en`=0, an `int_trig` in any state aborts the current pass. The next cycle issues the current `start_addr`.
- R9: With `ext_trig_en`=1, `int_trig` is ignored, `auto_mode` has no effect, and an `ext_trig` seen while idle starts one single pass.
- R10: `ext_trig` is ignored while a pass is in progress, and always when `ext_trig_en`=0.
- R11: `start_addr` and `end_addr` are sampled when a pass begins, including each continuous restart. Later changes take effect only at the next pass.
- R12: `conv_done` is ignored while idle: it raises no `done_valid` and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 4 | First channel of the window |
| end_addr | input | 4 | Final channel of the window |
| auto_mode | input | 1 | 1 selects continuous mode with the internal source |
| ext_trig_en | input | 1 | 1 selects the external trigger source |
| int_trig | input | 1 | Internal start/restart strobe |
| ext_trig | input | 1 | External trigger input |
| conv_done | input | 1 | Converter done strobe |
| conv_start | output | 1 | One-cycle start-conversion pulse |
| conv_chan | output | 4 | Channel address for the converter |
| done_valid | output | 1 | A channel finished this cycle |
| done_chan | output | 4 | Channel that finished |
| done_last | output | 1 | The finished channel ends the pass |
| busy | output | 1 | A pass is in progress |

## Verification
On every cycle, the assertions check the local relations between the outputs: start pulses stay isolated, a last flag always comes with a done, no done is reported while idle, and a done is followed by the next address or a wrap to the first address. They also check that an accepted trigger yields a start on the sampled first address, and that single-pass mode goes idle after the final done. Only the bench's scenarios can show whole-window properties. These are the complete ordered channel list of a pass, the shrinking of an inverted window, continuous repetition and its ending at a pass boundary, abort mid-pass, the address-sampling point, and which trigger inputs are ignored in each source mode.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cs_trigger.sv
// Qualifies trigger inputs against the selected source and derives run mode.
module cs_trigger (
  input  logic int_trig,
  input  logic ext_trig,
  input  logic ext_trig_en,
  input  logic auto_mode,
  input  logic busy,
  output logic pass_begin,
  output logic cont_mode
);
  logic int_ok;
  logic ext_ok;

  always_comb begin
    int_ok     = int_trig & ~ext_trig_en;
    ext_ok     = ext_trig & ext_trig_en & ~busy;
    pass_begin = int_ok | ext_ok;
    cont_mode  = auto_mode & ~ext_trig_en;
  end
endmodule

// File: rtl/cs_range.sv
// Holds the current channel and the sampled final channel of the window.
module cs_range #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  logic          load,
  input  logic          advance,
  output logic [AW-1:0] cur_ch,
  output logic          at_last
);
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] last_q, last_d;
  logic [AW-1:0] span_end;
  logic          reg_en;

  always_comb begin
    span_end = (end_addr > start_addr) ? end_addr : start_addr;
    cur_d    = cur_q;
    last_d   = last_q;
    if (load) begin
      cur_d  = start_addr;
      last_d = span_end;
    end else if (advance) begin
      cur_d  = cur_q + 1'b1;
    end
    reg_en = load | advance;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
    end else if (reg_en) begin
      cur_q  <= cur_d;
      last_q <= last_d;
    end
  end

  assign cur_ch  = cur_q;
  assign at_last = (cur_q == last_q);
endmodule

// File: rtl/cs_fsm.sv
// Issue / wait control loop of the sequencer.
module cs_fsm
  import chan_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pass_begin,
  input  logic cont_mode,
  input  logic conv_done,
  input  logic at_last,
  output logic busy,
  output logic issue,
  output logic done_hit
);
  seq_state_t st_q, st_d;
  logic       st_en;

  always_comb begin
    st_d = st_q;
    if (pass_begin) begin
      st_d = ST_ISSUE;
    end else begin
      case (st_q)
        ST_IDLE:  st_d = ST_IDLE;
        ST_ISSUE: st_d = ST_WAIT;
        ST_WAIT:  if (conv_done) st_d = (at_last && !cont_mode) ? ST_IDLE : ST_ISSUE;
        default:  st_d = ST_IDLE;
      endcase
    end
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign issue    = (st_q == ST_ISSUE);
  assign done_hit = (st_q == ST_WAIT) && conv_done;
endmodule

// File: rtl/chan_sequencer.sv
module chan_sequencer #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  logic          auto_mode,
  input  logic          ext_trig_en,
  input  logic          int_trig,
  input  logic          ext_trig,
  input  logic          conv_done,
  output logic          conv_start,
  output logic [AW-1:0] conv_chan,
  output logic          done_valid,
  output logic [AW-1:0] done_chan,
  output logic          done_last,
  output logic          busy
);
  logic          pass_begin;
  logic          cont_mode;
  logic          at_last;
  logic          done_hit;
  logic          issue;
  logic          load;
  logic          advance;
  logic [AW-1:0] cur_ch;

  cs_trigger u_trig (
    .int_trig    (int_trig),
    .ext_trig    (ext_trig),
    .ext_trig_en (ext_trig_en),
    .auto_mode   (auto_mode),
    .busy        (busy),
    .pass_begin  (pass_begin),
    .cont_mode   (cont_mode)
  );

  cs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass_begin (pass_begin),
    .cont_mode  (cont_mode),
    .conv_done  (conv_done),
    .at_last    (at_last),
    .busy       (busy),
    .issue      (issue),
    .done_hit   (done_hit)
  );

  always_comb begin
    load    = pass_begin | (done_hit & at_last & cont_mode);
    advance = done_hit & ~at_last & ~pass_begin;
  end

  cs_range #(.AW(AW)) u_range (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_addr (start_addr),
    .end_addr   (end_addr),
    .load       (load),
    .advance    (advance),
    .cur_ch     (cur_ch),
    .at_last    (at_last)
  );

  assign conv_start = issue;
  assign conv_chan  = cur_ch;
  assign done_valid = done_hit;
  assign done_chan  = cur_ch;
  assign done_last  = done_hit & at_last;
endmodule

// File: rtl/chan_sequencer_chk.sv
module chan_sequencer_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] start_addr,
  input logic          auto_mode,
  input logic          ext_trig_en,
  input logic          int_trig,
  input logic          ext_trig,
  input logic          conv_start,
  input logic [AW-1:0] conv_chan,
  input logic          done_valid,
  input logic [AW-1:0] done_chan,
  input logic          done_last,
  input logic          busy
);
  a_r4_last_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_last |-> done_valid);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r12_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !done_valid);

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (int_trig && !ext_trig_en) |=> (conv_start && conv_chan == $past(start_addr)));

  a_r9_ext_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_trig && ext_trig_en && !busy) |=> (conv_start && conv_chan == $past(start_addr)));

  a_r2_idle_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (done_last && !(auto_mode && !ext_trig_en) && !(int_trig && !ext_trig_en)) |=> !busy);

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (done_last && auto_mode && !ext_trig_en && !int_trig) |=>
      (conv_start && conv_chan == $past(start_addr)));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_last && !(int_trig && !ext_trig_en)) |=>
      (conv_start && conv_chan == $past(done_chan) + 1'b1));
endmodule

bind chan_sequencer chan_sequencer_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_addr  (start_addr),
  .auto_mode   (auto_mode),
  .ext_trig_en (ext_trig_en),
  .int_trig    (int_trig),
  .ext_trig    (ext_trig),
  .conv_start  (conv_start),
  .conv_chan   (conv_chan),
  .done_valid  (done_valid),
  .done_chan   (done_chan),
  .done_last   (done_last),
  .busy        (busy)
);

// File: tb/chan_sequencer_tb.sv
module chan_sequencer_tb;
  localparam int AW  = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] end_addr = '0;
  logic          auto_mode = 1'b0;
  logic          ext_trig_en = 1'b0;
  logic          int_trig = 1'b0;
  logic          ext_trig = 1'b0;
  logic          cv_done = 1'b0;
  logic          stray_done = 1'b0;
  logic          conv_done;
  logic          conv_start;
  logic [AW-1:0] conv_chan;
  logic          done_valid;
  logic [AW-1:0] done_chan;
  logic          done_last;
  logic          busy;

  assign conv_done = cv_done | stray_done;

  chan_sequencer #(.AW(AW)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_addr (start_addr), .end_addr (end_addr),
    .auto_mode (auto_mode), .ext_trig_en (ext_trig_en), .int_trig (int_trig),
    .ext_trig (ext_trig), .conv_done (conv_done), .conv_start (conv_start),
    .conv_chan (conv_chan), .done_valid (done_valid), .done_chan (done_chan),
    .done_last (done_last), .busy (busy)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Converter model: done strobe LAT cycles after a start; a new start cancels.
  int pend = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0; cv_done = 1'b0;
    end else if (conv_start) begin
      pend = LAT; cv_done = 1'b0;
    end else if (pend > 0) begin
      pend = pend - 1; cv_done = (pend == 0);
    end else begin
      cv_done = 1'b0;
    end
  end

  // Behavioural reference model: list of channels of the current pass.
  int mq[$];
  int midx = 0;
  bit mbusy = 0;
  bit missue = 0;
  bit m_dn, m_restart, m_extgo, m_cont;

  function automatic void build_list(int s, int e);
    mq = {};
    if (e > s) for (int i = s; i <= e; i++) mq.push_back(i);
    else mq.push_back(s);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbusy = 0; missue = 0; midx = 0; mq = {};
    end else begin
      m_dn      = mbusy && !missue && conv_done;
      m_restart = int_trig && !ext_trig_en;
      m_extgo   = ext_trig && ext_trig_en && !mbusy;
      m_cont    = auto_mode && !ext_trig_en;
      if (m_restart || m_extgo) begin
        build_list(int'(start_addr), int'(end_addr));
        midx = 0; mbusy = 1; missue = 1;
      end else if (missue) begin
        missue = 0;
      end else if (m_dn) begin
        if (midx == mq.size() - 1) begin
          if (m_cont) begin
            build_list(int'(start_addr), int'(end_addr));
            midx = 0; missue = 1;
          end else begin
            mbusy = 0;
          end
        end else begin
          midx = midx + 1; missue = 1;
        end
      end
    end
  end

  // Per-cycle comparison and observation of finished channels.
  int obs[$];
  int nstart = 0;
  bit e_dv;
  always @(negedge clk) begin
    if (rst_n) begin
      #5;
      e_dv = mbusy && !missue && conv_done;
      chk("R2 busy vs model", busy, mbusy);
      chk("R3 conv_start vs model", conv_start, mbusy && missue);
      if (mbusy && missue) chk("R3 conv_chan vs model", conv_chan, mq[midx]);
      chk("R4 done_valid vs model", done_valid, e_dv);
      if (e_dv) begin
        chk("R4 done_chan vs model", done_chan, mq[midx]);
        chk("R4 done_last vs model", done_last, midx == mq.size() - 1);
      end else begin
        chk("R4 done_last idle", done_last, 0);
      end
      if (done_valid) obs.push_back(int'(done_chan));
      if (conv_start) nstart++;
    end
  end

  task automatic clear_obs();
    @(negedge clk);
    obs = {}; nstart = 0;
  endtask

  task automatic pulse_int();
    @(negedge clk); int_trig = 1'b1;
    @(negedge clk); int_trig = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    int n = 0;
    @(negedge clk);
    while (busy && n < 600) begin @(negedge clk); n++; end
    chk({tag, " reaches idle"}, busy, 0);
  endtask

  task automatic wait_done(string tag, int cnt);
    int n = 0;
    while (obs.size() < cnt && n < 600) begin @(negedge clk); n++; end
    chk({tag, " done count reached"}, obs.size() >= cnt, 1);
  endtask

  task automatic chk_list(string tag, int exp[$]);
    chk({tag, " list length"}, obs.size(), exp.size());
    for (int i = 0; i < exp.size() && i < obs.size(); i++)
      chk({tag, " list entry"}, obs[i], exp[i]);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R1 busy in reset", busy, 0);
    chk("R1 conv_start in reset", conv_start, 0);
    chk("R1 done_valid in reset", done_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #5;
    chk("R1 busy after reset", busy, 0);
    chk("R1 conv_start after reset", conv_start, 0);

    // R2/R3/R4: single pass 2..5
    start_addr = 4'd2; end_addr = 4'd5; auto_mode = 1'b0; ext_trig_en = 1'b0;
    clear_obs();
    pulse_int();
    #5;
    chk("R3 first start after trigger", conv_start, 1);
    chk("R3 first channel", conv_chan, 2);
    wait_idle("R2 single pass");
    chk_list("R2 single pass 2..5", '{2, 3, 4, 5});
    chk("R3 one start per channel", nstart, 4);

    // R5: one-channel windows
    start_addr = 4'd7; end_addr = 4'd7;
    clear_obs(); pulse_int(); wait_idle("R5 equal");
    chk_list("R5 equal addresses", '{7});
    start_addr = 4'd9; end_addr = 4'd3;
    clear_obs(); pulse_int(); wait_idle("R5 inverted");
    chk_list("R5 inverted window", '{9});

    // R6/R7: continuous 1..3, stopped by clearing auto_mode
    start_addr = 4'd1; end_addr = 4'd3; auto_mode = 1'b1;
    clear_obs(); pulse_int();
    wait_done("R6 continuous", 7);
    auto_mode = 1'b0;
    wait_idle("R7 auto cleared");
    chk_list("R6 R7 continuous then stop", '{1, 2, 3, 1, 2, 3, 1, 2, 3});

    // R6/R7: one-channel continuous, stopped by enabling external source
    start_addr = 4'd4; end_addr = 4'd2; auto_mode = 1'b1;
    clear_obs(); pulse_int();
    wait_done("R6 single channel repeat", 3);
    ext_trig_en = 1'b1;
    wait_idle("R7 ext enabled");
    chk_list("R6 R7 repeat start channel", '{4, 4, 4, 4});
    ext_trig_en = 1'b0; auto_mode = 1'b0;

    // R8: abort mid-pass
    start_addr = 4'd0; end_addr = 4'd9;
    clear_obs(); pulse_int();
    wait_done("R8 before abort", 3);
    start_addr = 4'd12; end_addr = 4'd13;
    pulse_int();
    wait_idle("R8 after abort");
    chk_list("R8 abort restarts", '{0, 1, 2, 12, 13});

    // R9: external source, int_trig ignored, auto ignored
    ext_trig_en = 1'b1; auto_mode = 1'b1; start_addr = 4'd5; end_addr = 4'd6;
    clear_obs(); pulse_int();
    repeat (3) begin @(negedge clk); #5; chk("R9 int_trig ignored", busy, 0); end
    pulse_ext();
    wait_idle("R9 external pass");
    chk_list("R9 external single pass", '{5, 6});

    // R10: ext_trig while busy ignored, and ignored when source is internal
    clear_obs(); pulse_ext();
    wait_done("R10 first done", 1);
    pulse_ext();
    wait_idle("R10 busy retrigger");
    chk_list("R10 retrigger ignored", '{5, 6});
    chk("R10 starts count", nstart, 2);
    ext_trig_en = 1'b0; auto_mode = 1'b0;
    pulse_ext();
    repeat (3) begin @(negedge clk); #5; chk("R10 ext_trig with internal source", busy, 0); end

    // R11: addresses sampled at pass begin
    start_addr = 4'd0; end_addr = 4'd3;
    clear_obs(); pulse_int();
    wait_done("R11 first done", 1);
    start_addr = 4'd8; end_addr = 4'd10;
    wait_idle("R11 single");
    chk_list("R11 mid-pass write ignored", '{0, 1, 2, 3});
    start_addr = 4'd0; end_addr = 4'd1; auto_mode = 1'b1;
    clear_obs(); pulse_int();
    wait_done("R11 wrap first done", 1);
    end_addr = 4'd2;
    wait_done("R11 wrap", 5);
    auto_mode = 1'b0;
    wait_idle("R11 wrap stop");
    chk_list("R11 resampled at wrap", '{0, 1, 0, 1, 2, 0, 1, 2});

    // R12: stray done while idle
    clear_obs();
    @(negedge clk); stray_done = 1'b1;
    #5;
    chk("R12 no done_valid when idle", done_valid, 0);
    @(negedge clk); stray_done = 1'b0;
    #5;
    chk("R12 stays idle", busy, 0);
    chk("R12 no start", conv_start, 0);
    chk("R12 nothing observed", obs.size(), 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule